// File: doc/BRIEF.md
# Carry-Select Adder

This block adds two unsigned or two's-complement operands and an incoming carry. It produces a sum of the same width as the operands and a carry-out. It has no clock. The operands are split into a low group and a high group. The low group is added by a ripple chain, and the external carry enters at bit 0 of that chain.

The high group is added twice at the same time. One copy assumes an incoming carry of 0 and the other assumes 1. When the low chain's carry settles, it picks the high sum from one of the two copies. The high group therefore never waits for the low carry to ripple through it.

The carry-out is taken from the zero-assumption copy's carry, ORed with the one-assumption copy's carry gated by the low carry. This is the same as a two-way select, because the zero-assumption carry can only be 1 when the one-assumption carry is also 1. The operand width and the split position are parameters, and the split may be any value from 1 to the width minus 1.

Top module: `csel_adder`

## Requirements
- R1: `{cout, sum}` equals `a + b + cin` for every operand pair and carry-in.
- R2: The low SPLIT bits of `sum` equal the low SPLIT bits of `a[SPLIT-1:0] + b[SPLIT-1:0] + cin`, regardless of the high operand bits.
- R3: The external `cin` is the carry into bit 0. With all other inputs held, raising `cin` from 0 to 1 raises `{cout, sum}` by exactly one.
- R4: When the low group produces no carry, the high bits of `sum` equal `a_hi + b_hi`, truncated to the high-group width.
- R5: When the low group produces a carry, the high bits of `sum` equal `a_hi + b_hi + 1`, truncated to the high-group width.
- R6: `cout` equals the carry of `a_hi + b_hi`, ORed with the low-group carry ANDed with the carry of `a_hi + b_hi + 1`.
- R7: Whenever `a_hi + b_hi` overflows the high group on its own, `cout` is 1 whatever the low group does.
- R8: R1 holds for every split from 1 to WIDTH-1 and for widths other than 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| cout | output | 1 | Carry out of the top bit |

## Verification
The block has no state, so a fault shows at the ports as soon as the inputs settle. A bad select shows as high sum bits that are off by exactly one in the high group. This happens only on vectors where the low group carries or does not carry, depending on the fault. A wrong carry-out term shows only on vectors where exactly one of the two high-copy carries is 1. Such a fault needs the low carry to separate the cases, which is why every operand pair and carry-in is applied at 8 bits.

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int WIDTH = 8,
  parameter int SPLIT = WIDTH / 2
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int HW = WIDTH - SPLIT;

  logic [SPLIT:0]   lc;
  logic [SPLIT-1:0] lo_s;
  logic [HW:0]      z_c, o_c;
  logic [HW-1:0]    hi0, hi1;
  logic             c_mid, c_hi0, c_hi1;

  assign lc[0]  = cin;
  assign z_c[0] = 1'b0;
  assign o_c[0] = 1'b1;

  for (genvar i = 0; i < SPLIT; i++) begin : g_lo
    assign lo_s[i]  = a[i] ^ b[i] ^ lc[i];
    assign lc[i+1]  = (a[i] & b[i]) | (lc[i] & (a[i] ^ b[i]));
  end

  for (genvar j = 0; j < HW; j++) begin : g_hi
    logic p, g;
    assign p        = a[SPLIT+j] ^ b[SPLIT+j];
    assign g        = a[SPLIT+j] & b[SPLIT+j];
    assign hi0[j]   = p ^ z_c[j];
    assign z_c[j+1] = g | (p & z_c[j]);
    assign hi1[j]   = p ^ o_c[j];
    assign o_c[j+1] = g | (p & o_c[j]);
  end

  assign c_mid = lc[SPLIT];
  assign c_hi0 = z_c[HW];
  assign c_hi1 = o_c[HW];
  assign sum   = {(c_mid ? hi1 : hi0), lo_s};
  assign cout  = c_hi0 | (c_mid & c_hi1);
endmodule

module csel_adder_chk #(
  parameter int WIDTH = 8,
  parameter int SPLIT = WIDTH / 2
) (
  input logic [WIDTH-1:0]       a,
  input logic [WIDTH-1:0]       b,
  input logic                   cin,
  input logic [WIDTH-1:0]       sum,
  input logic                   cout,
  input logic                   c_mid,
  input logic [WIDTH-SPLIT-1:0] hi0,
  input logic [WIDTH-SPLIT-1:0] hi1,
  input logic                   c_hi0,
  input logic                   c_hi1
);
  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      // R7
      carry_order_chk: assert (!c_hi0 || c_hi1);
      // R6
      cout_sel_chk: assert (cout == (c_mid ? c_hi1 : c_hi0));
      // R4
      hi_zero_chk: assert (c_mid || sum[WIDTH-1:SPLIT] == hi0);
      // R5
      hi_one_chk: assert (!c_mid || sum[WIDTH-1:SPLIT] == hi1);
      // R1
      total_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}));
    end
  end
endmodule

bind csel_adder csel_adder_chk #(.WIDTH(WIDTH), .SPLIT(SPLIT)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .c_mid(c_mid),
  .hi0(hi0), .hi1(hi1), .c_hi0(c_hi0), .c_hi1(c_hi1)
);

// File: tb/csel_adder_test.sv
module csel_adder_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [7:0]  a, b;
  logic        cin;
  logic [7:0]  s4, s1, s7;
  logic        c4o, c1o, c7o;
  logic [15:0] wa, wb, ws;
  logic        wcin, wco;

  csel_adder uut (.a(a), .b(b), .cin(cin), .sum(s4), .cout(c4o));
  csel_adder #(.WIDTH(8), .SPLIT(1)) u_s1 (.a(a), .b(b), .cin(cin), .sum(s1), .cout(c1o));
  csel_adder #(.WIDTH(8), .SPLIT(7)) u_s7 (.a(a), .b(b), .cin(cin), .sum(s7), .cout(c7o));
  csel_adder #(.WIDTH(16), .SPLIT(5)) u_w16 (.a(wa), .b(wb), .cin(wcin), .sum(ws), .cout(wco));

  function automatic logic [8:0] ref8(logic [7:0] x, logic [7:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {8'd0, c};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #5_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] r0, r1;
    logic [4:0] lo, h0, h1;
    void'($urandom(32'd1234));
    a = '0; b = '0; cin = 1'b0; wa = '0; wb = '0; wcin = 1'b0;
    @(negedge clk);
    chk("R1 reset-state zero", {23'd0, c4o, s4}, 32'd0);

    // R3 directed: cin adds exactly one
    a = 8'h7F; b = 8'h80; cin = 1'b0;
    @(negedge clk); r0 = {c4o, s4};
    cin = 1'b1;
    @(negedge clk); r1 = {c4o, s4};
    chk("R3 cin increment", {23'd0, r1}, {23'd0, r0 + 9'd1});
    a = 8'h0F; b = 8'h00;
    cin = 1'b0; @(negedge clk); r0 = {c4o, s4};
    cin = 1'b1; @(negedge clk); r1 = {c4o, s4};
    chk("R3 cin ripples into high group", {23'd0, r1}, {23'd0, r0 + 9'd1});

    for (int v = 0; v < (1 << 17); v++) begin
      a = v[7:0]; b = v[15:8]; cin = v[16];
      @(negedge clk);
      chk("R1 full sum", {23'd0, c4o, s4}, {23'd0, ref8(a, b, cin)});
      lo = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, cin};
      h0 = {1'b0, a[7:4]} + {1'b0, b[7:4]};
      h1 = h0 + 5'd1;
      chk("R2 low bits", {28'd0, s4[3:0]}, {28'd0, lo[3:0]});
      if (!lo[4]) chk("R4 high without carry", {28'd0, s4[7:4]}, {28'd0, h0[3:0]});
      else        chk("R5 high with carry", {28'd0, s4[7:4]}, {28'd0, h1[3:0]});
      chk("R6 carry-out form", {31'd0, c4o}, {31'd0, h0[4] | (lo[4] & h1[4])});
      if (h0[4]) chk("R7 high overflow forces cout", {31'd0, c4o}, 32'd1);
      chk("R8 split 1", {23'd0, c1o, s1}, {23'd0, ref8(a, b, cin)});
      chk("R8 split 7", {23'd0, c7o, s7}, {23'd0, ref8(a, b, cin)});
    end

    for (int k = 0; k < 2000; k++) begin
      wa = 16'($urandom); wb = 16'($urandom); wcin = 1'($urandom);
      if (k == 0) begin wa = 16'hFFFF; wb = 16'h0000; wcin = 1'b1; end
      if (k == 1) begin wa = 16'hFFFF; wb = 16'hFFFF; wcin = 1'b1; end
      @(negedge clk);
      chk("R8 width 16 split 5", {15'd0, wco, ws},
          {15'd0, {1'b0, wa} + {1'b0, wb} + {16'd0, wcin}});
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule